// File: doc/BRIEF.md
# I2C Byte Shift Register with Acknowledge

This block is the serial data path of an I2C controller. An 8-bit data register and a hidden acknowledge bit form one 9-bit chain. Bits enter the chain through the acknowledge bit on each SCL rising edge. Bits leave through a separate one-bit transmit buffer, which is updated on each SCL falling edge. The buffer is loaded with bit 7 whenever the CPU writes a byte. During receive modes, the block returns the acknowledge bit during the ninth clock.

The bus level is always shifted back into the chain, even while the block is transmitting. After nine clocks, the register therefore holds the byte that actually appeared on the bus, and the acknowledge returned by the other device sits in the hidden bit. If arbitration is lost mid-byte, the register already holds the correct data. An external clock generator supplies single-cycle SCL edge strobes. An external state sequencer selects the direction and the acknowledge policy, reads the received acknowledge and reacts to the byte-done pulse. While the sequencer's interrupt flag is set, it asserts `hold_shift` to freeze the register.

Top module: `i2c_byte_shreg`

## Requirements
- R1: After reset, `cpu_rdata` is 0x00, `sda_pull_low` is 0, `byte_done` is 0 and `ack_rx` is 1.
- R2: In transmit mode (`rx_mode`=0), `sda_pull_low` is the inverse of the transmit buffer. After each of the first seven falling strobes of a byte, the buffer presents the next lower bit of the written byte, so the data goes out MSB first.
- R3: Received bits enter the chain on rising strobes. The first bit of a byte ends up in `cpu_rdata[7]`, and the ninth bit sampled is presented on `ack_rx`.
- R4: In transmit mode the sampled bus level is shifted in too. After nine rising strobes, `cpu_rdata` equals the byte seen on `sda_in`, even where it differs from the written byte.
- R5: On the falling strobe that follows the eighth rising strobe, the transmit buffer goes high, so SDA is released for the acknowledge clock while transmitting.
- R6: In receive mode, SDA is released during the eight data bits. From the falling strobe after the eighth rising strobe until the next falling strobe, `sda_pull_low` equals `ack_en`.
- R7: A CPU write is ignored when any rising strobe of the current byte has already been taken, or when it coincides with a rising strobe.
- R8: `byte_done` is a single-cycle pulse in the clock cycle after the ninth rising strobe of a byte.
- R9: While `hold_shift` is 1, SCL strobes have no effect on the register, the buffer or the bit count.
- R10: An accepted CPU write loads bit 7 of the written byte into the transmit buffer in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | CPU write strobe for the data register |
| cpu_wdata | input | 8 | Byte written by the CPU |
| cpu_rdata | output | 8 | Current data register contents |
| scl_rise | input | 1 | Single-cycle strobe marking an SCL rising edge |
| scl_fall | input | 1 | Single-cycle strobe marking an SCL falling edge |
| hold_shift | input | 1 | Freezes shifting while the interrupt flag is set |
| sda_in | input | 1 | Sampled SDA level (1 = high) |
| rx_mode | input | 1 | 0 = transmit, 1 = receive |
| ack_en | input | 1 | 1 = acknowledge a received byte, 0 = not-acknowledge |
| sda_pull_low | output | 1 | 1 drives SDA low, 0 releases it |
| ack_rx | output | 1 | Ninth bit shifted in (acknowledge from the bus) |
| byte_done | output | 1 | Pulse after the ninth rising strobe |

## Verification
The assertions take for granted that `scl_rise` and `scl_fall` are never high in the same cycle. They also assume that `rx_mode` and `ack_en` stay constant within a byte, and that every byte is framed by exactly nine rising strobes before the next one starts. The bench drives each strobe as a one-cycle pulse separated by idle cycles. It alternates rising and falling strobes. It changes the mode and acknowledge inputs only between bytes, when the bit count is back at zero. Collision and hold cases are issued at defined points in the byte, and the rest of that byte is always completed.

// File: rtl/i2c_byte_shreg_pkg.sv
package i2c_byte_shreg_pkg;

  typedef enum logic {
    XFER_TX = 1'b0,
    XFER_RX = 1'b1
  } xfer_dir_e;

  // Advance the rising-strobe count; wraps to zero after the ack bit.
  function automatic int unsigned next_count(input int unsigned cur, input int unsigned last);
    return (cur == last) ? 0 : cur + 1;
  endfunction

  // Pull-low request while receiving: only inside the ack window.
  function automatic logic rx_pull(input logic in_ack, input logic ack_on);
    return in_ack & ack_on;
  endfunction

endpackage

// File: rtl/i2c_byte_shreg_bitcnt.sv
module i2c_byte_shreg_bitcnt #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ev,
  input  logic             fall_ev,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ack_window_o,
  output logic             byte_done_o
);
  import i2c_byte_shreg_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic last_rise;
  assign last_rise = rise_ev && (cnt_o == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o        <= '0;
      ack_window_o <= 1'b0;
      byte_done_o  <= 1'b0;
    end else begin
      byte_done_o <= last_rise;
      if (rise_ev) begin
        cnt_o <= CNT_W'(next_count(int'(cnt_o), DATA_W));
      end
      if (fall_ev) begin
        ack_window_o <= (cnt_o == LAST);
      end
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= LAST);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |=> !byte_done_o);

  p_done_wraps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> (cnt_o == '0));

endmodule

// File: rtl/i2c_byte_shreg_chain.sv
module i2c_byte_shreg_chain #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_ev,
  input  logic              load_ev,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sda_in,
  output logic [DATA_W-1:0] data_o,
  output logic              ack_o
);

  // One shift step of the byte+ack chain: everything moves toward the MSB.
  function automatic logic [DATA_W:0] shift_step(input logic [DATA_W-1:0] d,
                                                 input logic a, input logic s);
    return {d[DATA_W-2:0], a, s};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      ack_o  <= 1'b1;
    end else if (load_ev) begin
      data_o <= load_data;
    end else if (rise_ev) begin
      {data_o, ack_o} <= shift_step(data_o, ack_o, sda_in);
    end
  end

  p_sample_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev && !load_ev |=> ack_o == $past(sda_in));

  p_ack_to_lsb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev && !load_ev |=> data_o[0] == $past(ack_o));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_ev && !load_ev |=> $stable(data_o) && $stable(ack_o));

endmodule

// File: rtl/i2c_byte_shreg_txbuf.sv
module i2c_byte_shreg_txbuf #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ev,
  input  logic             load_msb,
  input  logic             fall_ev,
  input  logic [CNT_W-1:0] cnt,
  input  logic             chain_msb,
  output logic             txb_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_o <= 1'b1;
    end else if (load_ev) begin
      txb_o <= load_msb;
    end else if (fall_ev) begin
      if (cnt == LAST) begin
        txb_o <= 1'b1;
      end else if (cnt != '0) begin
        txb_o <= chain_msb;
      end
    end
  end

  p_release_for_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev && !load_ev && (cnt == LAST) |=> txb_o);

  p_load_msb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> txb_o == $past(load_msb));

  p_next_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev && !load_ev && (cnt != '0) && (cnt != LAST) |=> txb_o == $past(chain_msb));

endmodule

// File: rtl/i2c_byte_shreg.sv
module i2c_byte_shreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              hold_shift,
  input  logic              sda_in,
  input  logic              rx_mode,
  input  logic              ack_en,
  output logic              sda_pull_low,
  output logic              ack_rx,
  output logic              byte_done
);
  import i2c_byte_shreg_pkg::*;

  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic             rise_ev;
  logic             fall_ev;
  logic             wr_accept;
  logic             mid_byte;
  logic [CNT_W-1:0] bit_cnt;
  logic             ack_window;
  logic             txb;
  xfer_dir_e        dir;

  assign rise_ev   = scl_rise & ~hold_shift;
  assign fall_ev   = scl_fall & ~hold_shift;
  assign mid_byte  = (bit_cnt != '0);
  assign wr_accept = cpu_wr & ~mid_byte & ~rise_ev;
  assign dir       = xfer_dir_e'(rx_mode);

  i2c_byte_shreg_bitcnt #(.DATA_W(DATA_W)) u_bitcnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_ev      (rise_ev),
    .fall_ev      (fall_ev),
    .cnt_o        (bit_cnt),
    .ack_window_o (ack_window),
    .byte_done_o  (byte_done)
  );

  i2c_byte_shreg_chain #(.DATA_W(DATA_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_ev   (rise_ev),
    .load_ev   (wr_accept),
    .load_data (cpu_wdata),
    .sda_in    (sda_in),
    .data_o    (cpu_rdata),
    .ack_o     (ack_rx)
  );

  i2c_byte_shreg_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ev   (wr_accept),
    .load_msb  (cpu_wdata[DATA_W-1]),
    .fall_ev   (fall_ev),
    .cnt       (bit_cnt),
    .chain_msb (cpu_rdata[DATA_W-1]),
    .txb_o     (txb)
  );

  always_comb begin
    if (dir == XFER_RX) begin
      sda_pull_low = rx_pull(ack_window, ack_en);
    end else begin
      sda_pull_low = ~txb;
    end
  end

  p_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && mid_byte && !rise_ev |=> $stable(cpu_rdata));

  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_shift && !cpu_wr |=> $stable(cpu_rdata) && $stable(bit_cnt) && $stable(txb));

  p_rx_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode && !ack_window |-> !sda_pull_low);

  p_tx_ack_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_mode && ack_window |-> !sda_pull_low);

endmodule

// File: tb/i2c_byte_shreg_tb_top.sv
module i2c_byte_shreg_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       scl_rise = 1'b0;
  logic       scl_fall = 1'b0;
  logic       hold_shift = 1'b0;
  logic       sda_in = 1'b1;
  logic       rx_mode = 1'b0;
  logic       ack_en = 1'b0;
  logic       sda_pull_low;
  logic       ack_rx;
  logic       byte_done;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  i2c_byte_shreg #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .hold_shift(hold_shift), .sda_in(sda_in), .rx_mode(rx_mode),
    .ack_en(ack_en), .sda_pull_low(sda_pull_low), .ack_rx(ack_rx),
    .byte_done(byte_done)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] b);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = b;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic do_rise(input logic s);
    @(negedge clk); scl_rise = 1'b1; sda_in = s;
    @(negedge clk); scl_rise = 1'b0;
  endtask

  task automatic do_fall();
    @(negedge clk); scl_fall = 1'b1;
    @(negedge clk); scl_fall = 1'b0;
  endtask

  task automatic t_reset();
    check(cpu_rdata == 8'h00, "R1", cpu_rdata, 0);
    check(sda_pull_low == 1'b0, "R1", sda_pull_low, 0);
    check(byte_done == 1'b0, "R1", byte_done, 0);
    check(ack_rx == 1'b1, "R1", ack_rx, 1);
  endtask

  // Transmit: interfere marks bits forced low by another device.
  task automatic t_tx(input logic [7:0] b, input logic [7:0] interfere, input logic slv_ack);
    logic [7:0] bus_byte;
    rx_mode = 1'b0;
    do_write(b);
    check(sda_pull_low == ~b[7], "R10", sda_pull_low, ~b[7]);
    for (int i = 7; i >= 0; i--) begin
      bus_byte[i] = b[i] & ~interfere[i];
      do_rise(bus_byte[i]);
      do_fall();
      if (i > 0) check(sda_pull_low == ~b[i-1], "R2", sda_pull_low, ~b[i-1]);
      else       check(sda_pull_low == 1'b0, "R5", sda_pull_low, 0);
    end
    do_rise(slv_ack);
    check(byte_done == 1'b1, "R8", byte_done, 1);
    @(negedge clk);
    check(byte_done == 1'b0, "R8", byte_done, 0);
    do_fall();
    check(cpu_rdata == bus_byte, "R4", cpu_rdata, bus_byte);
    check(ack_rx == slv_ack, "R3", ack_rx, slv_ack);
  endtask

  task automatic t_rx(input logic [7:0] b, input logic en);
    rx_mode = 1'b1;
    ack_en = en;
    for (int i = 7; i >= 0; i--) begin
      do_rise(b[i]);
      check(sda_pull_low == 1'b0, "R6", sda_pull_low, 0);
      do_fall();
    end
    check(sda_pull_low == en, "R6", sda_pull_low, en);
    do_rise(~en);
    check(sda_pull_low == en, "R6", sda_pull_low, en);
    check(byte_done == 1'b1, "R8", byte_done, 1);
    check(ack_rx == ~en, "R3", ack_rx, ~en);
    do_fall();
    check(sda_pull_low == 1'b0, "R6", sda_pull_low, 0);
    check(cpu_rdata == b, "R3", cpu_rdata, b);
  endtask

  task automatic t_write_busy();
    logic [7:0] snap;
    logic pl;
    rx_mode = 1'b0;
    do_write(8'hA5);
    do_rise(1'b1);
    do_fall();
    snap = cpu_rdata;
    pl = sda_pull_low;
    do_write(8'h3C);
    check(cpu_rdata == snap, "R7", cpu_rdata, snap);
    check(sda_pull_low == pl, "R7", sda_pull_low, pl);
    for (int i = 0; i < 8; i++) begin
      do_rise(1'b1);
      do_fall();
    end
    check(cpu_rdata == 8'hFF, "R7", cpu_rdata, 8'hFF);
    // write colliding with a rising strobe at the start of a byte
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = 8'h00; scl_rise = 1'b1; sda_in = 1'b1;
    @(negedge clk); cpu_wr = 1'b0; scl_rise = 1'b0;
    check(cpu_rdata == 8'hFF, "R7", cpu_rdata, 8'hFF);
    do_fall();
    for (int i = 0; i < 8; i++) begin
      do_rise(1'b1);
      do_fall();
    end
  endtask

  task automatic t_hold();
    logic [7:0] snap;
    rx_mode = 1'b0;
    do_write(8'h5A);
    snap = cpu_rdata;
    hold_shift = 1'b1;
    for (int i = 0; i < 3; i++) begin
      do_rise(1'b0);
      do_fall();
    end
    check(cpu_rdata == snap, "R9", cpu_rdata, snap);
    check(sda_pull_low == 1'b1, "R9", sda_pull_low, 1);
    hold_shift = 1'b0;
    t_tx(8'h5A, 8'h00, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx(8'hC3, 8'h00, 1'b0);
    t_tx(8'hB7, 8'h10, 1'b1);
    t_rx(8'h96, 1'b1);
    t_rx(8'h2D, 1'b0);
    t_write_busy();
    t_hold();
    t_rx(8'h81, 1'b1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule